// File: doc/BRIEF.md
# DSSS Preamble and Header Bit Generator

This block produces, one bit per clock, the serial framing that a direct-sequence wireless LAN transmitter sends before a packet: a sync run, a start-frame delimiter and a 48-bit header. The header holds a rate code, a service byte, a duration field and a CRC-16. After the header it asks a payload source for exactly as many bits as fit the programmed air time, and passes them on. Every bit leaves through a self-synchronising scrambler. Each output bit carries a rate tag, so that the downstream spreader and modulator know how to send it.

A controller sets a mode byte and a duration in microseconds, then raises the transmit enable. The rising edge starts one packet. The duration may still be rewritten while the sync and delimiter are going out. The generator raises a ready flag shortly before payload bits are needed, and then strobes a request for each payload bit. Dropping the enable ends the packet at once. A new packet needs a fresh rising edge.

Top module: `plcp_hdr_gen`

## Requirements
- R1: During and right after synchronous reset, tx_valid, tx_bit, rate_tag, ready and data_req are all 0.
- R2: A packet starts only on a rising edge of tx_en seen while idle. tx_en held high through reset, or held high after a packet ends, starts nothing.
- R3: Long format (mode_sel[4]=0, or mode_sel[6:5]=00): 128 one bits, then the delimiter 0xF3A0 sent LSB first.
- R4: Short format (mode_sel[4]=1 with mode_sel[6:5]≠00): 56 zero bits, then the delimiter 0x05CF sent LSB first. Mode 0x10 behaves as long-format 1 Mb/s.
- R5: The header fields are sent in this order, each LSB first. The signal byte is 0x0A, 0x14, 0x37 or 0x6E for mode_sel[6:5] = 0, 1, 2 or 3. The service byte has bit 7 equal to dur_us[16] and all other bits 0. The 16-bit length field is dur_us[15:0]. mode_sel[7] and mode_sel[3:0] are ignored.
- R6: The header is followed by a 16-bit CRC. The register is preset to 0xFFFF. Each header bit, in send order, is XORed with register bit 15. The register then shifts left, and when that XOR is 1 it is XORed with 0x1021. The ones complement of the register is sent from bit 15 down to bit 0.
- R7: Every output bit is z = b XOR z(n-4) XOR z(n-7). At the start of each packet the history is preloaded with 0x6C (long) or 0x1B (short), where history bit k holds z(n-1-k).
- R8: rate_tag encoding is 0 = 1 Mb/s, 1 = 2 Mb/s, 2 = 5.5 Mb/s, 3 = 11 Mb/s. Sync and delimiter bits carry 0. Header and CRC bits carry 1 in short format and 0 in long format. Payload bits carry mode_sel[6:5].
- R9: The number of payload bits requested for a duration D = dur_us[16:0] is D, 2D, floor(11D/2) or 11D for rates 0 to 3. D = 0 gives no request.
- R10: dur_us is captured when the first header bit is produced. Writes during sync and delimiter take effect; later writes do not affect the packet.
- R11: ready is high for the last 8 CRC bit slots and through the whole payload, so it leads the first data_req by exactly 8 cycles. ready falls when the last request ends.
- R12: tx_en sampled low during a packet returns the block to idle. After that edge, tx_valid, ready and data_req are 0.
- R13: pay_bit is taken at the clock edge that ends a cycle with data_req high. Its scrambled value appears on tx_bit, with tx_valid, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; a rising edge starts a packet, low aborts |
| mode_sel | input | 8 | Mode byte; [6:5] rate, [4] short format |
| dur_us | input | 17 | Packet duration in microseconds |
| pay_bit | input | 1 | Payload bit, taken while data_req is high |
| tx_bit | output | 1 | Scrambled output bit |
| tx_valid | output | 1 | tx_bit carries a frame bit |
| rate_tag | output | 2 | Rate at which tx_bit is to be sent |
| ready | output | 1 | Payload requests are imminent or in progress |
| data_req | output | 1 | Payload bit request strobe |

## Verification
Two functions can fall in the same cycle: a payload request, and the abort caused by tx_en falling. The bench provokes this by dropping tx_en in the middle of a long 1 Mb/s packet, while data_req is high. It then checks that all outputs clear on the next edge, and that the bits already sent match the expected stream. A second overlap is a duration write landing in the sync phase, just before the capture point, compared with one landing after the header. The expected length field and request count judge which value took effect.

// File: rtl/plcp_pkg.sv
package plcp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_SFD,
    PH_HDR,
    PH_CRC,
    PH_DATA,
    PH_DONE
  } phase_t;

  typedef enum logic [1:0] {
    RATE_1M  = 2'd0,
    RATE_2M  = 2'd1,
    RATE_5M5 = 2'd2,
    RATE_11M = 2'd3
  } rate_t;

  localparam int SFD_W = 16;
  localparam int HDR_W = 32;
  localparam int CRC_W = 16;

  function automatic logic [7:0] signal_code(input rate_t r);
    case (r)
      RATE_1M:  signal_code = 8'h0A;
      RATE_2M:  signal_code = 8'h14;
      RATE_5M5: signal_code = 8'h37;
      default:  signal_code = 8'h6E;
    endcase
  endfunction

endpackage

// File: rtl/plcp_scrambler.sv
module plcp_scrambler #(
  parameter int         HIST_W     = 7,
  parameter int         TAP        = 4,
  parameter logic [6:0] SEED_LONG  = 7'h6C,
  parameter logic [6:0] SEED_SHORT = 7'h1B
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic short_fmt,
  input  logic step,
  input  logic din,
  output logic dout
);

  logic [HIST_W-1:0] hist_q;

  // history bit k holds the output from k+1 steps ago
  assign dout = din ^ hist_q[TAP-1] ^ hist_q[HIST_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (load) begin
      hist_q <= short_fmt ? SEED_SHORT : SEED_LONG;
    end else if (step) begin
      hist_q <= {hist_q[HIST_W-2:0], dout};
    end
  end

endmodule

// File: rtl/plcp_crc16.sv
module plcp_crc16 #(
  parameter int               W      = 16,
  parameter logic [W-1:0]     POLY   = 16'h1021,
  parameter logic [W-1:0]     PRESET = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q;
  logic         fb;

  assign fb  = din ^ crc_q[W-1];
  assign crc = crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= PRESET;
    end else if (clear) begin
      crc_q <= PRESET;
    end else if (step) begin
      crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

endmodule

// File: rtl/plcp_paycount.sv
module plcp_paycount
  import plcp_pkg::*;
#(
  parameter int LEN_W = 17,
  parameter int PAY_W = LEN_W + 4
) (
  input  rate_t            rate,
  input  logic [LEN_W-1:0] dur,
  output logic [PAY_W-1:0] total
);

  logic [PAY_W-1:0] d_ext;
  logic [PAY_W-1:0] d_x11;

  assign d_ext = PAY_W'(dur);
  assign d_x11 = (d_ext << 3) + (d_ext << 1) + d_ext;

  always_comb begin
    case (rate)
      RATE_1M:  total = d_ext;
      RATE_2M:  total = d_ext << 1;
      RATE_5M5: total = d_x11 >> 1;
      default:  total = d_x11;
    endcase
  end

endmodule

// File: rtl/plcp_hdr_gen.sv
module plcp_hdr_gen
  import plcp_pkg::*;
#(
  parameter int          LEN_W      = 17,
  parameter int          SYNC_LONG  = 128,
  parameter int          SYNC_SHORT = 56,
  parameter int          READY_LEAD = 8,
  parameter logic [15:0] SFD_LONG   = 16'hF3A0,
  parameter logic [15:0] SFD_SHORT  = 16'h05CF,
  parameter logic [6:0]  SEED_LONG  = 7'h6C,
  parameter logic [6:0]  SEED_SHORT = 7'h1B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic [7:0]       mode_sel,
  input  logic [LEN_W-1:0] dur_us,
  input  logic             pay_bit,
  output logic             tx_bit,
  output logic             tx_valid,
  output logic [1:0]       rate_tag,
  output logic             ready,
  output logic             data_req
);

  localparam int CNT_W = $clog2(SYNC_LONG + 1);
  localparam int PAY_W = LEN_W + 4;
  localparam logic [CNT_W-1:0] LAST_SFD = CNT_W'(SFD_W - 1);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_CRC = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] RDY_IDX  = CNT_W'(CRC_W - READY_LEAD);

  phase_t           phase_q, nxt_phase;
  logic [CNT_W-1:0] idx_q, nxt_idx;
  rate_t            rate_q;
  logic             short_q;
  logic [LEN_W-1:0] dur_q;
  logic [PAY_W-1:0] pay_left_q;
  logic [PAY_W-1:0] pay_total;
  logic             en_q;

  logic             active, go, start, src, scr_out;
  logic             start_short;
  logic [CNT_W-1:0] sync_last;
  logic [15:0]      sfd_w;
  logic [HDR_W-1:0] hdr_w;
  logic [7:0]       service;
  logic [CRC_W-1:0] crc_val;
  logic [1:0]       tag;

  assign active      = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
  assign go          = active && tx_en;
  assign start       = (phase_q == PH_IDLE) && tx_en && !en_q;
  assign start_short = mode_sel[4] && (mode_sel[6:5] != 2'b00);
  assign sync_last   = short_q ? CNT_W'(SYNC_SHORT - 1) : CNT_W'(SYNC_LONG - 1);
  assign sfd_w       = short_q ? SFD_SHORT : SFD_LONG;
  assign service     = {dur_q[LEN_W-1], 7'b0};
  assign hdr_w       = {dur_q[15:0], service, signal_code(rate_q)};

  // bit source for the slot currently held in phase_q / idx_q
  always_comb begin
    case (phase_q)
      PH_SYNC: src = !short_q;
      PH_SFD:  src = sfd_w[idx_q[3:0]];
      PH_HDR:  src = hdr_w[idx_q[4:0]];
      PH_CRC:  src = !crc_val[4'd15 - idx_q[3:0]];
      PH_DATA: src = pay_bit;
      default: src = 1'b0;
    endcase
  end

  always_comb begin
    case (phase_q)
      PH_HDR, PH_CRC: tag = short_q ? 2'(RATE_2M) : 2'(RATE_1M);
      PH_DATA:        tag = rate_q;
      default:        tag = 2'(RATE_1M);
    endcase
  end

  always_comb begin
    nxt_phase = phase_q;
    nxt_idx   = idx_q;
    case (phase_q)
      PH_IDLE: if (start) begin
        nxt_phase = PH_SYNC;
        nxt_idx   = '0;
      end
      PH_SYNC: if (idx_q == sync_last) begin
        nxt_phase = PH_SFD;
        nxt_idx   = '0;
      end else begin
        nxt_idx = idx_q + 1'b1;
      end
      PH_SFD: if (idx_q == LAST_SFD) begin
        nxt_phase = PH_HDR;
        nxt_idx   = '0;
      end else begin
        nxt_idx = idx_q + 1'b1;
      end
      PH_HDR: if (idx_q == LAST_HDR) begin
        nxt_phase = PH_CRC;
        nxt_idx   = '0;
      end else begin
        nxt_idx = idx_q + 1'b1;
      end
      PH_CRC: if (idx_q == LAST_CRC) begin
        nxt_phase = (pay_total == '0) ? PH_DONE : PH_DATA;
        nxt_idx   = '0;
      end else begin
        nxt_idx = idx_q + 1'b1;
      end
      PH_DATA: if (pay_left_q == PAY_W'(1)) nxt_phase = PH_DONE;
      PH_DONE: if (!tx_en) nxt_phase = PH_IDLE;
      default: nxt_phase = PH_IDLE;
    endcase
    if (active && !tx_en) begin
      nxt_phase = PH_IDLE;
      nxt_idx   = '0;
    end
  end

  plcp_scrambler #(
    .HIST_W    (7),
    .TAP       (4),
    .SEED_LONG (SEED_LONG),
    .SEED_SHORT(SEED_SHORT)
  ) u_scr (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .short_fmt(start_short),
    .step     (go),
    .din      (src),
    .dout     (scr_out)
  );

  plcp_crc16 #(
    .W     (CRC_W),
    .POLY  (16'h1021),
    .PRESET(16'hFFFF)
  ) u_crc (
    .clk  (clk),
    .rst  (rst),
    .clear(start),
    .step (go && (phase_q == PH_HDR)),
    .din  (src),
    .crc  (crc_val)
  );

  plcp_paycount #(
    .LEN_W(LEN_W),
    .PAY_W(PAY_W)
  ) u_cnt (
    .rate (rate_q),
    .dur  (dur_q),
    .total(pay_total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      idx_q      <= '0;
      rate_q     <= RATE_1M;
      short_q    <= 1'b0;
      dur_q      <= '0;
      pay_left_q <= '0;
      en_q       <= 1'b1;
      tx_bit     <= 1'b0;
      tx_valid   <= 1'b0;
      rate_tag   <= 2'b00;
      ready      <= 1'b0;
      data_req   <= 1'b0;
    end else begin
      phase_q  <= nxt_phase;
      idx_q    <= nxt_idx;
      en_q     <= tx_en;
      tx_valid <= go;
      tx_bit   <= go ? scr_out : 1'b0;
      rate_tag <= go ? tag : 2'b00;
      ready    <= (nxt_phase == PH_DATA) ||
                  ((nxt_phase == PH_CRC) && (nxt_idx >= RDY_IDX));
      data_req <= (nxt_phase == PH_DATA);
      if (start) begin
        rate_q  <= rate_t'(mode_sel[6:5]);
        short_q <= start_short;
      end
      if (phase_q == PH_SFD && nxt_phase == PH_HDR) dur_q <= dur_us;
      if (phase_q == PH_CRC && nxt_phase == PH_DATA) pay_left_q <= pay_total;
      else if (phase_q == PH_DATA) pay_left_q <= pay_left_q - 1'b1;
    end
  end

endmodule

// File: rtl/plcp_hdr_gen_chk.sv
module plcp_hdr_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_en,
  input logic       tx_valid,
  input logic [1:0] rate_tag,
  input logic       ready,
  input logic       data_req
);

  p_req_needs_ready_r11: assert property (@(posedge clk) disable iff (rst)
    data_req |-> ready);

  p_ready_drops_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(data_req) |-> !ready);

  p_abort_clears_r12: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!tx_valid && !data_req && !ready));

  p_req_emits_r13: assert property (@(posedge clk) disable iff (rst)
    (data_req && tx_en) |=> tx_valid);

  p_data_tag_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (data_req && $past(data_req) && tx_en) |=> $stable(rate_tag));

endmodule

bind plcp_hdr_gen plcp_hdr_gen_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_en   (tx_en),
  .tx_valid(tx_valid),
  .rate_tag(rate_tag),
  .ready   (ready),
  .data_req(data_req)
);

// File: tb/plcp_hdr_gen_test.sv
`timescale 1ns/1ps
module plcp_hdr_gen_test;

  localparam int MAXB = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0;
  logic [7:0]  mode_sel = 8'h00;
  logic [16:0] dur_us = '0;
  logic        pay_bit = 1'b0;
  logic        tx_bit, tx_valid, ready, data_req;
  logic [1:0]  rate_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  logic       src_b   [0:MAXB-1];
  logic       exp_b   [0:MAXB-1];
  logic [1:0] exp_t   [0:MAXB-1];
  logic       got_b   [0:MAXB-1];
  logic [1:0] got_t   [0:MAXB-1];
  logic       pay_src [0:MAXB-1];
  int n_exp, exp_cnt, hdr_lo;

  always #2 clk = ~clk;

  plcp_hdr_gen uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .mode_sel(mode_sel), .dur_us(dur_us),
    .pay_bit(pay_bit), .tx_bit(tx_bit), .tx_valid(tx_valid), .rate_tag(rate_tag),
    .ready(ready), .data_req(data_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pay_bits(input int r, input int d);
    case (r)
      0: return d;
      1: return 2 * d;
      2: return (11 * d) / 2;
      default: return 11 * d;
    endcase
  endfunction

  function automatic logic [7:0] sig_of(input int r);
    case (r)
      0: return 8'h0A;
      1: return 8'h14;
      2: return 8'h37;
      default: return 8'h6E;
    endcase
  endfunction

  function automatic logic [15:0] crc_of(input logic [31:0] w);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      logic fb = w[i] ^ c[15];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return ~c;
  endfunction

  task automatic build(input logic [7:0] m, input logic [16:0] d);
    int r = int'(m[6:5]);
    bit sh = m[4] && (r != 0);
    int n = 0;
    logic [15:0] sfd = sh ? 16'h05CF : 16'hF3A0;
    logic [31:0] hw = {d[15:0], d[16], 7'b0, sig_of(r)};
    logic [15:0] cv = crc_of(hw);
    logic [6:0] h = sh ? 7'h1B : 7'h6C;
    for (int i = 0; i < (sh ? 56 : 128); i++) begin src_b[n] = !sh; exp_t[n] = 0; n++; end
    for (int i = 0; i < 16; i++) begin src_b[n] = sfd[i]; exp_t[n] = 0; n++; end
    hdr_lo = n;
    for (int i = 0; i < 32; i++) begin src_b[n] = hw[i]; exp_t[n] = sh ? 2'd1 : 2'd0; n++; end
    for (int i = 0; i < 16; i++) begin src_b[n] = cv[15-i]; exp_t[n] = sh ? 2'd1 : 2'd0; n++; end
    exp_cnt = pay_bits(r, int'(d));
    for (int k = 0; k < exp_cnt && n < MAXB; k++) begin
      src_b[n] = pay_src[k]; exp_t[n] = 2'(r); n++;
    end
    n_exp = n;
    for (int i = 0; i < n; i++) begin
      logic z = src_b[i] ^ h[3] ^ h[6];
      exp_b[i] = z;
      h = {h[5:0], z};
    end
  endtask

  task automatic cmp_seg(input int lo, input int hi, input string req);
    int bad = 0;
    int first = -1;
    for (int i = lo; i < hi; i++) begin
      if (got_b[i] !== exp_b[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(got_b[first]), int'(exp_b[first]));
  endtask

  // chg_at: valid-bit count at which dur_us is rewritten (-1: never)
  // abort_at: valid-bit count at which tx_en is dropped (-1: never)
  task automatic run_pkt(input logic [7:0] m, input logic [16:0] d1, input int chg_at,
                         input logic [16:0] d2, input int abort_at);
    int r = int'(m[6:5]);
    bit sh = m[4] && (r != 0);
    int cap = sh ? 72 : 144;
    logic [16:0] deff = (chg_at >= 0 && chg_at < cap - 4) ? d2 : d1;
    int nv = 0, nreq = 0, cyc = 0, f_rdy = -1, f_req = -1;
    bit aborted = 0;
    string sreq = sh ? "R4" : "R3";
    for (int k = 0; k < MAXB; k++) pay_src[k] = 1'($urandom);
    build(m, deff);
    @(negedge clk);
    mode_sel = m;
    dur_us = d1;
    tx_en = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "watchdog", cyc, 20000);
        break;
      end
      if (tx_valid) begin
        if (nv < MAXB) begin got_b[nv] = tx_bit; got_t[nv] = rate_tag; end
        nv++;
      end
      if (ready && f_rdy < 0) f_rdy = cyc;
      if (data_req) begin
        if (f_req < 0) f_req = cyc;
        pay_bit = (nreq < MAXB) ? pay_src[nreq] : 1'b0;
        nreq++;
      end
      if (chg_at >= 0 && nv == chg_at) dur_us = d2;
      if (abort_at >= 0 && nv == abort_at) begin
        tx_en = 1'b0;
        @(negedge clk);
        chk(!tx_valid && !ready && !data_req, "R12 abort clears outputs",
            int'({tx_valid, ready, data_req}), 0);
        aborted = 1;
        break;
      end
      if (nv > 0 && !tx_valid && !ready && !data_req) break;
    end
    cmp_seg(0, hdr_lo, sreq);
    cmp_seg(hdr_lo, hdr_lo + 32, (chg_at >= 0) ? "R10 length capture" : "R5");
    cmp_seg(hdr_lo + 32, hdr_lo + 48, "R6");
    if (aborted) begin
      cmp_seg(hdr_lo + 48, nv, "R7 R13 payload before abort");
    end else begin
      int tb = 0;
      chk(nv == n_exp, "R9 total bits", nv, n_exp);
      chk(nreq == exp_cnt, "R9 payload requests", nreq, exp_cnt);
      cmp_seg(hdr_lo + 48, (nv < n_exp) ? nv : n_exp, "R7 R13 payload");
      for (int i = 0; i < nv && i < n_exp; i++) if (got_t[i] !== exp_t[i]) tb++;
      chk(tb == 0, "R8 rate tags", tb, 0);
      if (exp_cnt > 0) chk(f_req - f_rdy == 8, "R11 ready lead", f_req - f_rdy, 8);
      else chk(f_rdy > 0 && f_req < 0, "R11 ready without payload", f_req, -1);
      // hold enable high: no new packet may start
      begin
        int extra = 0;
        for (int i = 0; i < 20; i++) begin
          @(negedge clk);
          if (tx_valid || ready) extra++;
        end
        chk(extra == 0, "R2 no restart while held", extra, 0);
      end
      tx_en = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tx_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(!tx_valid && !tx_bit && rate_tag == 0 && !ready && !data_req, "R1 reset outputs",
        int'({tx_valid, tx_bit, rate_tag, ready, data_req}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_valid && !ready && !data_req, "R1 after reset", int'({tx_valid, ready, data_req}), 0);
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (tx_valid) seen++;
      end
      chk(seen == 0, "R2 enable held through reset", seen, 0);
    end
    tx_en = 1'b0;
    repeat (2) @(negedge clk);

    run_pkt(8'h00, 17'd5, -1, 17'd0, -1);
    run_pkt(8'h70, 17'd3, -1, 17'd0, -1);
    run_pkt(8'h50, 17'd3, -1, 17'd0, -1);
    run_pkt(8'h1F, 17'd4, -1, 17'd0, -1);
    run_pkt(8'h20, 17'd0, -1, 17'd0, -1);
    run_pkt(8'hE9, 17'd7, -1, 17'd0, -1);
    run_pkt(8'h40, 17'd2, 10, 17'd9, -1);
    run_pkt(8'h60, 17'd4, 200, 17'd40, -1);
    run_pkt(8'h30, 17'd6, 20, 17'd1, -1);
    run_pkt(8'h00, 17'h10005, -1, 17'd0, 250);
    for (int p = 0; p < 8; p++) begin
      logic [7:0] m = 8'($urandom) & 8'h8F;
      m[6:5] = 2'($urandom);
      m[4] = 1'($urandom);
      run_pkt(m, 17'($urandom % 160), -1, 17'd0, -1);
    end

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule